// File: doc/BRIEF.md
# Per-Channel Image Statistics Tracker

This block watches the packet events of a camera serial receiver and keeps a small set of image statistics for each of sixteen virtual channels. Two event streams feed it. The packet controller reports every decoded header with its virtual channel, data type and word count. The line buffer reports every long packet it has stored, tagged with its virtual channel. Only long packets update the per-channel byte count and data type. Long packets are those whose data type is 0x18 or higher. The line counter moves when a packet reaches the line buffer, not when its header is decoded.

Software or a debug bus reads the statistics through a simple read port. Each channel exposes two 32-bit words at byte addresses computed from the channel number. Read data appears one clock after the request. Nothing in the block is writable, and every field clears on reset.

Top module: `vc_stats_tracker`

## Requirements
- R1: After a synchronous active-low reset, every channel's line count, byte count and data type is zero, and `rd_data` is zero.
- R2: A header event with data type of 0x18 or more loads that channel's byte count with the word count and its data type with the header's data type.
- R3: A header event whose data type is below 0x18 (0x17 and under, including sync codes such as 0x00) changes no statistic. 0x18 itself counts as a long packet.
- R4: Each line-buffer write event adds one to the tagged channel's line count. A header event never changes any line count.
- R5: The 16-bit line count wraps from 0xFFFF to 0x0000.
- R6: A header event and a line-buffer write in the same cycle both take effect, on the same channel or on different channels.
- R7: Channel n's first word is at byte address 0x60 + 8n, with the line count in bits 31:16 and the byte count in bits 15:0. Its second word is at 0x64 + 8n, with the data type in bits 5:0 and bits 31:6 zero.
- R8: A read of any other address returns 0x00000000. This covers addresses below 0x60, addresses above 0xDC, and addresses whose two low bits are not zero.
- R9: `rd_data` presents the addressed word one cycle after `rd_en` is sampled high, showing the state from before that edge's updates. It holds its value while `rd_en` is low.
- R10: The sixteen channels are independent. An event on one channel leaves every other channel's fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Packet header event strobe |
| hdr_vc | input | 4 | Virtual channel of the header |
| hdr_dtype | input | 6 | Data type of the header |
| hdr_wcount | input | 16 | Word count (payload bytes) of the header |
| lbw_valid | input | 1 | Line-buffer write event strobe |
| lbw_vc | input | 4 | Virtual channel of the stored packet |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, registered |

## Verification
A header update and a line-buffer write can land on the same clock edge. The bench drives both strobes in one cycle in two ways: once on the same channel, and once on two different channels. It then reads both statistics words of every channel involved. The read must show the new byte count and data type together with a line count that rose by exactly one, and no other channel may have moved. A read issued in the very cycle of an update is also checked: it must return the value from before that update.

// File: rtl/vcst_pkg.sv
// Package: shared constants and types for the per-channel statistics tracker.
// Assumes byte addressing of 32-bit words on the read port.
package vcst_pkg;
    localparam int VC_W    = 4;
    localparam int DT_W    = 6;
    localparam int WC_W    = 16;
    localparam int LC_W    = 16;
    localparam int DATA_W  = 32;
    localparam logic [DT_W-1:0] LONG_DT_MIN = 6'h18;

    typedef struct packed {
        logic [LC_W-1:0] lines;
        logic [WC_W-1:0] bytes;
        logic [DT_W-1:0] dtype;
    } chan_stats_t;
endpackage

// File: rtl/vcst_channel.sv
// Module: statistics registers for one virtual channel.
// Assumes the header strobe it receives has already been filtered to long
// packets. It matches both event streams against its own channel number.
module vcst_channel
    import vcst_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            long_hdr,
    input  logic [VC_W-1:0] hdr_vc,
    input  logic [DT_W-1:0] hdr_dtype,
    input  logic [WC_W-1:0] hdr_wcount,
    input  logic            lbw_valid,
    input  logic [VC_W-1:0] lbw_vc,
    output logic            hdr_take,
    output logic            line_take,
    output chan_stats_t     stats
);
    localparam logic [VC_W-1:0] MY_VC = VC_W'(CH_ID);

    // Purpose: decide whether either event targets this channel.
    always_comb begin
        hdr_take  = long_hdr && (hdr_vc == MY_VC);
        line_take = lbw_valid && (lbw_vc == MY_VC);
    end

    // Purpose: load header fields for long packets of this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stats.bytes <= '0;
            stats.dtype <= '0;
        end else if (hdr_take) begin
            stats.bytes <= hdr_wcount;
            stats.dtype <= hdr_dtype;
        end
    end

    // Purpose: count stored lines, wrapping at the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stats.lines <= '0;
        else if (line_take)
            stats.lines <= stats.lines + 1'b1;
    end

    // R4: without a line-buffer write for this channel the count holds
    assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_take |=> $stable(stats.lines));
    // R3: header fields only move on a filtered long-packet header
    assert_hdr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_take |=> ($stable(stats.bytes) && $stable(stats.dtype)));
    // R3: a stored data type is either the reset value or a long-packet code
    assert_dtype_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stats.dtype == '0) || (stats.dtype >= LONG_DT_MIN));
endmodule

// File: rtl/vcst_readport.sv
// Module: address decode and registered read mux over all channel stats.
// Assumes word-aligned byte addresses. Each channel occupies 8 bytes
// starting at BASE_ADDR. Any other address reads as zero.
module vcst_readport
    import vcst_pkg::*;
#(
    parameter int NUM_VC    = 16,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_stats_t       stats [NUM_VC],
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int STRIDE = 8;
    localparam int SPAN   = NUM_VC * STRIDE;
    localparam int IDX_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;

    int                offset;
    logic              mapped;
    logic              second_word;
    logic [IDX_W-1:0]  ch_idx;
    logic [DATA_W-1:0] rd_next;

    // Purpose: turn the byte address into channel index and word select.
    always_comb begin
        offset      = int'(rd_addr) - BASE_ADDR;
        mapped      = (offset >= 0) && (offset < SPAN) && (rd_addr[1:0] == 2'b00);
        second_word = rd_addr[2];
        ch_idx      = IDX_W'(offset / STRIDE);
    end

    // Purpose: pack the selected word, zero when unmapped.
    always_comb begin
        rd_next = '0;
        if (mapped) begin
            if (second_word)
                rd_next = {{(DATA_W-DT_W){1'b0}}, stats[ch_idx].dtype};
            else
                rd_next = {stats[ch_idx].lines, stats[ch_idx].bytes};
        end
    end

    // Purpose: register read data one cycle after the request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    // R9: idle cycles leave the read data unchanged
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R8: addresses below the window read as zero
    assert_low_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(rd_addr) < BASE_ADDR)) |=> (rd_data == '0));
    // R8: misaligned addresses read as zero
    assert_misaligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr[1:0] != 2'b00)) |=> (rd_data == '0));
    // R7: the second word of a channel has its upper bits clear
    assert_word2_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[2]) |=> (rd_data[DATA_W-1:DT_W] == '0));
endmodule

// File: rtl/vc_stats_tracker.sv
// Module: top of the per-virtual-channel image statistics tracker.
// Filters header events down to long packets, fans both event streams out
// to one register set per channel, and serves reads of all of them.
// Assumes each event stream carries at most one event per cycle.
module vc_stats_tracker
    import vcst_pkg::*;
#(
    parameter int NUM_VC    = 16,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    input  logic [VC_W-1:0]   hdr_vc,
    input  logic [DT_W-1:0]   hdr_dtype,
    input  logic [WC_W-1:0]   hdr_wcount,
    input  logic              lbw_valid,
    input  logic [VC_W-1:0]   lbw_vc,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic        long_hdr;
    logic [NUM_VC-1:0] hdr_take_v;
    logic [NUM_VC-1:0] line_take_v;
    chan_stats_t stats [NUM_VC];

    // Purpose: accept only headers of long packets for statistics.
    always_comb long_hdr = hdr_valid && (hdr_dtype >= LONG_DT_MIN);

    // Purpose: one independent statistics set per virtual channel.
    for (genvar g = 0; g < NUM_VC; g++) begin : g_chan
        vcst_channel #(.CH_ID(g)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .long_hdr   (long_hdr),
            .hdr_vc     (hdr_vc),
            .hdr_dtype  (hdr_dtype),
            .hdr_wcount (hdr_wcount),
            .lbw_valid  (lbw_valid),
            .lbw_vc     (lbw_vc),
            .hdr_take   (hdr_take_v[g]),
            .line_take  (line_take_v[g]),
            .stats      (stats[g])
        );
    end

    vcst_readport #(
        .NUM_VC    (NUM_VC),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .stats   (stats),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R10: a header updates at most one channel
    assert_one_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hdr_take_v));
    // R10: a line-buffer write bumps at most one channel
    assert_one_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_take_v));
    // R3: a short or sync header reaches no channel
    assert_short_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (hdr_dtype < LONG_DT_MIN)) |-> (hdr_take_v == '0));
    // R6: a line write is still taken while a long header lands
    assert_both_events_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (long_hdr && lbw_valid) |-> ($countones(hdr_take_v) == 1 && $countones(line_take_v) == 1));
endmodule

// File: tb/test_vc_stats_tracker.sv
// Scoreboard bench: the driver task models the expected statistics and
// queues the expected read word. A monitor pops and compares each result.
module test_vc_stats_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [3:0]  hdr_vc = '0;
    logic [5:0]  hdr_dtype = '0;
    logic [15:0] hdr_wcount = '0;
    logic        lbw_valid = 1'b0;
    logic [3:0]  lbw_vc = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [31:0] value;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [15:0] m_lines [16];
    logic [15:0] m_bytes [16];
    logic [5:0]  m_dt    [16];

    logic        rd_pend = 1'b0;
    logic [31:0] last_rd = '0;

    always #4 clk = ~clk;

    vc_stats_tracker i_vc_stats_tracker (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_vc(hdr_vc), .hdr_dtype(hdr_dtype), .hdr_wcount(hdr_wcount),
        .lbw_valid(lbw_valid), .lbw_vc(lbw_vc),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Expected word from the model (R7, R8 address map and layout).
    function automatic logic [31:0] model_word(input logic [7:0] a);
        int ch;
        if (a < 8'h60 || a > 8'hDC || a[1:0] != 2'b00) return 32'h0;
        ch = (int'(a) - 'h60) / 8;
        if (a[2]) return {26'h0, m_dt[ch]};
        return {m_lines[ch], m_bytes[ch]};
    endfunction

    // Driver: one cycle of stimulus, queueing the expected read result.
    task automatic step(input logic hv, input logic [3:0] hvc, input logic [5:0] hdt,
                        input logic [15:0] hwc, input logic lv, input logic [3:0] lvc,
                        input logic re, input logic [7:0] ra, input string tag);
        exp_t e;
        @(negedge clk);
        hdr_valid = hv; hdr_vc = hvc; hdr_dtype = hdt; hdr_wcount = hwc;
        lbw_valid = lv; lbw_vc = lvc; rd_en = re; rd_addr = ra;
        if (re) begin
            e.value = model_word(ra);
            e.tag   = tag;
            exp_q.push_back(e);
        end
        if (hv && hdt >= 6'h18) begin
            m_bytes[hvc] = hwc;
            m_dt[hvc]    = hdt;
        end
        if (lv) m_lines[lvc] = m_lines[lvc] + 16'd1;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, 4'h0, 6'h0, 16'h0, 1'b0, 4'h0, 1'b1, a, tag);
    endtask

    task automatic hdr(input logic [3:0] vc, input logic [5:0] dt, input logic [15:0] wc);
        step(1'b1, vc, dt, wc, 1'b0, 4'h0, 1'b0, 8'h0, "");
    endtask

    task automatic line(input logic [3:0] vc);
        step(1'b0, 4'h0, 6'h0, 16'h0, 1'b1, vc, 1'b0, 8'h0, "");
    endtask

    task automatic idle();
        step(1'b0, 4'h0, 6'h0, 16'h0, 1'b0, 4'h0, 1'b0, 8'h0, "");
    endtask

    always @(posedge clk) rd_pend <= rst_n && rd_en;

    // Monitor: compare each read result, and check holding on idle cycles (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_pend) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9: unexpected read result %h expected none", rd_data);
                end else begin
                    e = exp_q.pop_front();
                    checks++;
                    if (rd_data !== e.value) begin
                        errors++;
                        $display("FAIL %s: rd_data=%h expected %h", e.tag, rd_data, e.value);
                    end
                end
            end else begin
                checks++;
                if (rd_data !== last_rd) begin
                    errors++;
                    $display("FAIL R9: idle rd_data=%h expected %h", rd_data, last_rd);
                end
            end
            last_rd = rd_data;
        end else begin
            last_rd = 32'h0;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_lines[i] = '0; m_bytes[i] = '0; m_dt[i] = '0;
        end
        repeat (3) @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (rd_data !== 32'h0) begin
            errors++;
            $display("FAIL R1: rd_data=%h expected %h", rd_data, 32'h0);
        end
        rd(8'h60, "R1"); rd(8'h64, "R1"); rd(8'hD8, "R1"); rd(8'hDC, "R1");

        // R2, R7: long header loads bytes and data type of channel 3
        hdr(4'd3, 6'h2A, 16'h1234);
        rd(8'h78, "R2"); rd(8'h7C, "R7");
        rd(8'h70, "R10"); rd(8'h80, "R10");

        // R3: short codes ignored, 0x18 accepted
        hdr(4'd3, 6'h17, 16'h9999);
        rd(8'h78, "R3"); rd(8'h7C, "R3");
        hdr(4'd3, 6'h00, 16'h7777);
        rd(8'h7C, "R3");
        hdr(4'd3, 6'h18, 16'h0042);
        rd(8'h78, "R3"); rd(8'h7C, "R3");

        // R4: line writes count, headers do not
        line(4'd3); line(4'd3); line(4'd3);
        rd(8'h78, "R4");
        hdr(4'd3, 6'h24, 16'h0010);
        rd(8'h78, "R4");

        // R9: read in the same cycle as an update sees the old value
        step(1'b0, 4'h0, 6'h0, 16'h0, 1'b1, 4'd3, 1'b1, 8'h78, "R9");
        rd(8'h78, "R9");
        idle(); idle();

        // R6: simultaneous events on different channels, then on one channel
        step(1'b1, 4'd7, 6'h1E, 16'h0500, 1'b1, 4'd9, 1'b0, 8'h0, "");
        rd(8'h98, "R6"); rd(8'h9C, "R6"); rd(8'hA8, "R6"); rd(8'hAC, "R6");
        step(1'b1, 4'd3, 6'h3F, 16'hFFFF, 1'b1, 4'd3, 1'b0, 8'h0, "");
        rd(8'h78, "R6"); rd(8'h7C, "R6");

        // R8: unmapped and misaligned addresses
        rd(8'h5C, "R8"); rd(8'h00, "R8"); rd(8'hE0, "R8");
        rd(8'hFC, "R8"); rd(8'h79, "R8"); rd(8'h7A, "R8");

        // R10, R7: give every channel distinct stats and read all back
        for (int c = 0; c < 16; c++) begin
            hdr(4'(c), 6'(6'h18 + c), 16'(16'h0100 * c + 7));
            for (int k = 0; k < c; k++) line(4'(c));
        end
        for (int c = 0; c < 16; c++) begin
            rd(8'(8'h60 + 8 * c), "R10");
            rd(8'(8'h64 + 8 * c), "R7");
        end

        // R5: wrap of the line counter on channel 15
        for (int k = 0; k < 65535 - 15; k++) line(4'd15);
        rd(8'hD8, "R5");
        line(4'd15);
        rd(8'hD8, "R5");
        idle(); idle(); idle();

        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9: %0d reads missing expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9: watchdog expired, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule